// File: doc/BRIEF.md
# Rectangle Copy Address Sequencer

This block drives a block-transfer datapath that moves a rectangle of pixels inside a one-bit-per-pixel frame buffer. A line of the frame buffer is 2048 pixels wide, which is 128 sixteen-bit words. The visible region is 1280 by 1024 pixels. The block does not touch memory itself. A start pulse captures the source corner, the destination corner, the width and the height. The block then chooses a walking direction that stays safe when the two areas overlap. For every line it emits a stream of commands, each accepted with a valid/ready handshake. Each command carries a source word address, a destination word address, a per-pixel keep mask, the alignment shift and a command kind.

Each line begins with a line-header command. This command carries the destination page byte that the datapath latches before the line starts. An optional dummy source read may follow the header to prime the shifter. After that come the word commands. The first and last word commands are masked at the rectangle edges. Word commands between them write all sixteen pixels. A one-cycle done pulse marks the end of the copy. A mode byte shows the block-transfer shift while a copy runs and the normal setting at all other times.

Top module: `blit_copy_seq`

## Requirements
- R1: When dst_y is not greater than src_y, the copy runs forward. Lines are walked from the top row, from the left word rightward, and addresses increase by one per word. Otherwise the copy runs backward. It starts at row y+height-1 and at the word that holds pixel x+width-1, and addresses decrease by one per word.
- R2: A word address is row*128 + (x>>4). Successive lines differ by ±128 words.
- R3: A line has (a>>4) − (b>>4) + 1 word commands. Here a is the larger and b the smaller of the two horizontal edge pixels x and x+width−1.
- R4: In cmd_keep, bit 15 is the leftmost pixel of a word and a 1 keeps the destination pixel. The first and last word commands have 1s exactly on the pixels that lie outside [dst_x, dst_x+width−1]. This holds in both directions.
- R5: When a line touches one word only, its single word command carries the OR of both edge keep patterns. Middle words carry an all-zero keep mask.
- R6: cmd_shift equals (dst_x[3:0] − src_x[3:0]) mod 16 on every command of the copy.
- R7: mode is 0xE0 while idle. From the cycle after the start until the last command, it is 0x80 | cmd_shift. It returns to 0xE0 in the done cycle.
- R8: A forward line holds one dummy-read command (cmd_kind 1) when dst_x[3:0] < src_x[3:0]. A backward line holds one when the low four bits of dst_x+width−1 are greater than those of src_x+width−1. The dummy read carries the line's first source address and the line's first destination address. The following word command repeats the same destination and the source address moved one word in the walking direction.
- R9: Every line starts with a header command (cmd_kind 0) with keep mask 0. It carries the line's first source and destination addresses. Word commands are cmd_kind 2. cmd_page is 0x0C OR'd with destination address bit 16.
- R10: A width or height of zero produces no command. done rises two cycles after the start cycle.
- R11: While cmd_valid is high and cmd_ready is low, the command holds steady and stays valid.
- R12: done is high for exactly one cycle after the final word command is accepted. A start pulse while a copy runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a copy when idle |
| src_x | input | 11 | Source left pixel |
| src_y | input | 10 | Source top row |
| dst_x | input | 11 | Destination left pixel |
| dst_y | input | 10 | Destination top row |
| width | input | 11 | Width in pixels |
| height | input | 10 | Height in rows |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Datapath accepts the command |
| cmd_kind | output | 2 | 0 header, 1 dummy read, 2 word |
| cmd_src | output | 17 | Source word address |
| cmd_dst | output | 17 | Destination word address |
| cmd_keep | output | 16 | Keep mask, bit 15 = leftmost pixel |
| cmd_shift | output | 4 | Alignment shift |
| cmd_page | output | 8 | Destination page byte for the header |
| mode | output | 8 | Mode byte |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Completion pulse |

## Verification
The assertions assume that both rectangles lie inside the 2048-pixel line and inside the 1024 rows, so that no address wraps. They also assume that cmd_ready is a plain input that may drop in any cycle. The stepping and stall properties rely on the corners staying inside the frame. Every directed case picks corners and sizes that fit in the frame, including a case on row 600 that sets the page bit. The ready line is driven either always high or from a bench shift register that produces irregular stalls.

// File: rtl/blit_seq_pkg.sv
package blit_seq_pkg;
  localparam int unsigned WORD_BITS = 16;
  localparam int unsigned WORD_LOG2 = 4;

  typedef logic [WORD_BITS-1:0] wmask_t;

  typedef enum logic [1:0] {
    CMD_ROW  = 2'd0,
    CMD_PRE  = 2'd1,
    CMD_WORD = 2'd2
  } cmd_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PREP, ST_ROW, ST_PRE, ST_WORD, ST_FIN
  } walk_st_e;

  localparam logic [7:0] MODE_NORMAL = 8'hE0;
  localparam logic [2:0] MODE_BLOCK  = 3'b100;
  localparam logic [7:0] PAGE_TAG    = 8'h0C;

  // keep pixels left of position lo (bit 15 = leftmost pixel)
  function automatic wmask_t keep_before(input logic [WORD_LOG2-1:0] lo);
    return ~(wmask_t'('1) >> lo);
  endfunction

  // keep pixels right of position lo
  function automatic wmask_t keep_after(input logic [WORD_LOG2-1:0] lo);
    return (wmask_t'('1) >> 1) >> lo;
  endfunction

  function automatic logic [WORD_LOG2-1:0] align_shift(input logic [WORD_LOG2-1:0] d,
                                                       input logic [WORD_LOG2-1:0] s);
    return d - s;
  endfunction

  function automatic logic needs_preread(input logic fwd,
                                         input logic [WORD_LOG2-1:0] d,
                                         input logic [WORD_LOG2-1:0] s);
    return fwd ? (d < s) : (d > s);
  endfunction
endpackage

// File: rtl/blit_setup.sv
module blit_setup
  import blit_seq_pkg::*;
#(
  parameter int XW = 11,
  parameter int YW = 10
) (
  input  logic [XW-1:0]                   sx,
  input  logic [XW-1:0]                   dx,
  input  logic [XW-1:0]                   w,
  input  logic [YW-1:0]                   sy,
  input  logic [YW-1:0]                   dy,
  input  logic [YW-1:0]                   h,
  output logic                            fwd,
  output logic                            pre,
  output logic                            empty,
  output logic [YW+XW-WORD_LOG2-1:0]      src_row0,
  output logic [YW+XW-WORD_LOG2-1:0]      dst_row0,
  output logic [XW-WORD_LOG2:0]           words,
  output wmask_t                          lead_keep,
  output wmask_t                          trail_keep,
  output logic [WORD_LOG2-1:0]            shift
);
  localparam int CW = XW - WORD_LOG2 + 1;

  logic [XW-1:0] sx_tail, dx_tail, d_first, d_last, s_first;
  logic [YW-1:0] sy_tail, dy_tail, s_row, d_row;
  logic [CW-1:0] col_hi, col_lo;

  always_comb begin
    sx_tail = sx + w - XW'(1);
    dx_tail = dx + w - XW'(1);
    sy_tail = sy + h - YW'(1);
    dy_tail = dy + h - YW'(1);
    fwd     = (dy <= sy);
    d_first = fwd ? dx : dx_tail;
    d_last  = fwd ? dx_tail : dx;
    s_first = fwd ? sx : sx_tail;
    s_row   = fwd ? sy : sy_tail;
    d_row   = fwd ? dy : dy_tail;
    col_hi  = fwd ? {1'b0, d_last[XW-1:WORD_LOG2]}  : {1'b0, d_first[XW-1:WORD_LOG2]};
    col_lo  = fwd ? {1'b0, d_first[XW-1:WORD_LOG2]} : {1'b0, d_last[XW-1:WORD_LOG2]};
    words   = col_hi - col_lo + CW'(1);
    lead_keep  = fwd ? keep_before(d_first[WORD_LOG2-1:0]) : keep_after(d_first[WORD_LOG2-1:0]);
    trail_keep = fwd ? keep_after(d_last[WORD_LOG2-1:0])   : keep_before(d_last[WORD_LOG2-1:0]);
    shift   = align_shift(dx[WORD_LOG2-1:0], sx[WORD_LOG2-1:0]);
    pre     = needs_preread(fwd, d_first[WORD_LOG2-1:0], s_first[WORD_LOG2-1:0]);
    empty   = (w == '0) || (h == '0);
  end

  assign src_row0 = {s_row, s_first[XW-1:WORD_LOG2]};
  assign dst_row0 = {d_row, d_first[XW-1:WORD_LOG2]};
endmodule

// File: rtl/blit_walker.sv
module blit_walker
  import blit_seq_pkg::*;
#(
  parameter int XW = 11,
  parameter int YW = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        cmd_ready,
  input  logic                        fwd,
  input  logic                        pre,
  input  logic                        empty,
  input  logic [YW+XW-WORD_LOG2-1:0]  src_row0,
  input  logic [YW+XW-WORD_LOG2-1:0]  dst_row0,
  input  logic [YW-1:0]               rows,
  input  logic [XW-WORD_LOG2:0]       words,
  input  wmask_t                      lead_keep,
  input  wmask_t                      trail_keep,
  output logic                        cmd_valid,
  output cmd_kind_e                   cmd_kind,
  output logic [YW+XW-WORD_LOG2-1:0]  cmd_src,
  output logic [YW+XW-WORD_LOG2-1:0]  cmd_dst,
  output wmask_t                      cmd_keep,
  output logic                        busy,
  output logic                        active,
  output logic                        done,
  output logic                        prep_evt
);
  localparam int AW        = YW + XW - WORD_LOG2;
  localparam int CW        = XW - WORD_LOG2 + 1;
  localparam int ROW_WORDS = 1 << (XW - WORD_LOG2);

  walk_st_e        st;
  logic [AW-1:0]   src_rs, dst_rs, src_cur, dst_cur;
  logic [YW-1:0]   rows_left;
  logic [CW-1:0]   word_idx;

  logic [AW-1:0]   col_step, row_step;
  logic            cmd_fire, last_word_w, last_row_w, first_word_w;

  assign col_step     = fwd ? AW'(1) : {AW{1'b1}};
  assign row_step     = fwd ? AW'(ROW_WORDS) : (AW'(0) - AW'(ROW_WORDS));
  assign cmd_fire     = cmd_valid && cmd_ready;
  assign last_word_w  = (word_idx == (words - CW'(1)));
  assign first_word_w = (word_idx == '0);
  assign last_row_w   = (rows_left == YW'(1));
  assign prep_evt     = (st == ST_PREP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      src_rs    <= '0;
      dst_rs    <= '0;
      src_cur   <= '0;
      dst_cur   <= '0;
      rows_left <= '0;
      word_idx  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) st <= ST_PREP;
        ST_PREP: begin
          src_rs    <= src_row0;
          dst_rs    <= dst_row0;
          rows_left <= rows;
          word_idx  <= '0;
          st        <= empty ? ST_FIN : ST_ROW;
        end
        ST_ROW: if (cmd_fire) begin
          src_cur  <= src_rs;
          dst_cur  <= dst_rs;
          word_idx <= '0;
          st       <= pre ? ST_PRE : ST_WORD;
        end
        ST_PRE: if (cmd_fire) begin
          src_cur <= src_cur + col_step;
          st      <= ST_WORD;
        end
        ST_WORD: if (cmd_fire) begin
          src_cur  <= src_cur + col_step;
          dst_cur  <= dst_cur + col_step;
          word_idx <= word_idx + CW'(1);
          if (last_word_w) begin
            if (last_row_w) begin
              st <= ST_FIN;
            end else begin
              rows_left <= rows_left - YW'(1);
              src_rs    <= src_rs + row_step;
              dst_rs    <= dst_rs + row_step;
              st        <= ST_ROW;
            end
          end
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_valid = (st == ST_ROW) || (st == ST_PRE) || (st == ST_WORD);
    cmd_kind  = (st == ST_ROW) ? CMD_ROW : ((st == ST_PRE) ? CMD_PRE : CMD_WORD);
    cmd_src   = (st == ST_ROW) ? src_rs : src_cur;
    cmd_dst   = (st == ST_ROW) ? dst_rs : dst_cur;
    cmd_keep  = '0;
    if (st == ST_WORD) begin
      if (first_word_w && last_word_w) cmd_keep = lead_keep | trail_keep;
      else if (first_word_w)           cmd_keep = lead_keep;
      else if (last_word_w)            cmd_keep = trail_keep;
    end
    busy   = (st != ST_IDLE);
    active = (st != ST_IDLE) && (st != ST_FIN);
    done   = (st == ST_FIN);
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_src) && $stable(cmd_dst) &&
                                   $stable(cmd_keep) && $stable(cmd_kind))); // R11
  AST_PRE_THEN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_kind == CMD_PRE) |=> (cmd_kind == CMD_WORD && $stable(cmd_dst))); // R8
  AST_FWD_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_kind == CMD_WORD && !last_word_w && fwd)
      |=> (cmd_src == $past(cmd_src) + AW'(1))); // R1
  AST_BWD_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_kind == CMD_WORD && !last_word_w && !fwd)
      |=> (cmd_src == $past(cmd_src) - AW'(1))); // R1
  AST_HDR_NEXT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_kind == CMD_WORD && last_word_w && !last_row_w)
      |=> (cmd_kind == CMD_ROW && cmd_valid)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !cmd_valid)); // R12
endmodule

// File: rtl/blit_copy_seq.sv
module blit_copy_seq
  import blit_seq_pkg::*;
#(
  parameter int XW         = 11,
  parameter int YW         = 10,
  parameter int PAGE_SHIFT = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [XW-1:0]                src_x,
  input  logic [YW-1:0]                src_y,
  input  logic [XW-1:0]                dst_x,
  input  logic [YW-1:0]                dst_y,
  input  logic [XW-1:0]                width,
  input  logic [YW-1:0]                height,
  output logic                         cmd_valid,
  input  logic                         cmd_ready,
  output logic [1:0]                   cmd_kind,
  output logic [YW+XW-WORD_LOG2-1:0]   cmd_src,
  output logic [YW+XW-WORD_LOG2-1:0]   cmd_dst,
  output logic [WORD_BITS-1:0]         cmd_keep,
  output logic [WORD_LOG2-1:0]         cmd_shift,
  output logic [7:0]                   cmd_page,
  output logic [7:0]                   mode,
  output logic                         busy,
  output logic                         done
);
  localparam int AW = YW + XW - WORD_LOG2;
  localparam int CW = XW - WORD_LOG2 + 1;

  logic [XW-1:0] sx_q, dx_q, w_q;
  logic [YW-1:0] sy_q, dy_q, h_q;

  logic          fwd, pre, empty, active, prep_evt;
  logic [AW-1:0] src_row0, dst_row0;
  logic [CW-1:0] words;
  wmask_t        lead_keep, trail_keep, keep_w;
  logic [WORD_LOG2-1:0] shift;
  cmd_kind_e     kind_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sx_q <= '0; dx_q <= '0; w_q <= '0;
      sy_q <= '0; dy_q <= '0; h_q <= '0;
    end else if (start && !busy) begin
      sx_q <= src_x; dx_q <= dst_x; w_q <= width;
      sy_q <= src_y; dy_q <= dst_y; h_q <= height;
    end
  end

  blit_setup #(.XW(XW), .YW(YW)) u_setup (
    .sx(sx_q), .dx(dx_q), .w(w_q), .sy(sy_q), .dy(dy_q), .h(h_q),
    .fwd(fwd), .pre(pre), .empty(empty),
    .src_row0(src_row0), .dst_row0(dst_row0), .words(words),
    .lead_keep(lead_keep), .trail_keep(trail_keep), .shift(shift)
  );

  blit_walker #(.XW(XW), .YW(YW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_ready(cmd_ready),
    .fwd(fwd), .pre(pre), .empty(empty),
    .src_row0(src_row0), .dst_row0(dst_row0), .rows(h_q), .words(words),
    .lead_keep(lead_keep), .trail_keep(trail_keep),
    .cmd_valid(cmd_valid), .cmd_kind(kind_w), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
    .cmd_keep(keep_w), .busy(busy), .active(active), .done(done), .prep_evt(prep_evt)
  );

  assign cmd_kind  = kind_w;
  assign cmd_keep  = keep_w;
  assign cmd_shift = shift;
  assign cmd_page  = PAGE_TAG | 8'(cmd_dst >> PAGE_SHIFT);
  assign mode      = active ? {MODE_BLOCK, 1'b0, shift} : MODE_NORMAL;

  AST_EMPTY_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (prep_evt && empty) |=> (done && !cmd_valid)); // R10
  AST_SHIFT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && $past(cmd_valid)) |-> $stable(cmd_shift)); // R6
endmodule

// File: tb/sim_blit_copy_seq.sv
module sim_blit_copy_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [10:0] src_x = '0, dst_x = '0, width = '0;
  logic [9:0]  src_y = '0, dst_y = '0, height = '0;
  logic        cmd_ready = 1'b1;
  logic        cmd_valid, busy, done;
  logic [1:0]  cmd_kind;
  logic [16:0] cmd_src, cmd_dst;
  logic [15:0] cmd_keep;
  logic [3:0]  cmd_shift;
  logic [7:0]  cmd_page, mode;

  always #10 clk = ~clk;

  blit_copy_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
    .width(width), .height(height),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_keep(cmd_keep),
    .cmd_shift(cmd_shift), .cmd_page(cmd_page), .mode(mode),
    .busy(busy), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_exp;
  int e_kind[0:2047];
  int e_src[0:2047];
  int e_dst[0:2047];
  int e_keep[0:2047];
  logic [7:0] lfsr = 8'h5A;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int k, input int s, input int d, input int kp);
    e_kind[n_exp] = k; e_src[n_exp] = s; e_dst[n_exp] = d; e_keep[n_exp] = kp;
    n_exp++;
  endtask

  // expected command list derived pixel by pixel
  task automatic build_expected(input int sx, input int sy, input int dx, input int dy,
                                input int w, input int h);
    bit fwd;
    int fx, lx, fsx, nw, s, d, inc;
    bit pre;
    n_exp = 0;
    if (w == 0 || h == 0) return;
    fwd = (dy <= sy);
    inc = fwd ? 1 : -1;
    fx  = fwd ? dx : dx + w - 1;
    lx  = fwd ? dx + w - 1 : dx;
    fsx = fwd ? sx : sx + w - 1;
    nw  = fwd ? (lx / 16 - fx / 16 + 1) : (fx / 16 - lx / 16 + 1);
    pre = fwd ? ((fx % 16) < (fsx % 16)) : ((fx % 16) > (fsx % 16));
    for (int r = 0; r < h; r++) begin
      int srow, drow;
      srow = fwd ? sy + r : sy + h - 1 - r;
      drow = fwd ? dy + r : dy + h - 1 - r;
      s = srow * 128 + fsx / 16;
      d = drow * 128 + fx / 16;
      push(0, s, d, 0);
      if (pre) begin
        push(1, s, d, 0);
        s += inc;
      end
      for (int k = 0; k < nw; k++) begin
        int kp;
        kp = 0;
        for (int b = 0; b < 16; b++) begin
          int px;
          px = (d % 128) * 16 + (15 - b);
          if (px < dx || px > dx + w - 1) kp |= (1 << b);
        end
        push(2, s, d, kp);
        s += inc;
        d += inc;
      end
    end
  endtask

  task automatic run_copy(input string name, input int sx, input int sy, input int dx,
                          input int dy, input int w, input int h,
                          input bit stalls, input bit inject);
    int got, bad, cyc, exp_shift;
    longint bad_act, bad_exp;
    bit seen_done, hold, hold_bad, first_seen, mode_bad;
    logic [16:0] h_src, h_dst;
    logic [15:0] h_keep;
    logic [1:0]  h_kind;
    build_expected(sx, sy, dx, dy, w, h);
    exp_shift = ((dx % 16) - (sx % 16) + 16) % 16;
    @(negedge clk);
    src_x = 11'(sx); src_y = 10'(sy); dst_x = 11'(dx); dst_y = 10'(dy);
    width = 11'(w); height = 10'(h);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0; bad = 0; cyc = 0; seen_done = 0; hold = 0; hold_bad = 0;
    first_seen = 0; mode_bad = 0; bad_act = 0; bad_exp = 0;
    h_src = '0; h_dst = '0; h_keep = '0; h_kind = '0;
    while (!seen_done && cyc < 20000) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cmd_ready = stalls ? (lfsr[0] | lfsr[2]) : 1'b1;
      start = (inject && cyc == 5);
      if (inject && cyc == 5) begin
        src_x = 11'd3; dst_x = 11'd900; width = 11'd7; height = 10'd9;
      end
      if (hold && !(cmd_valid && cmd_src == h_src && cmd_dst == h_dst &&
                    cmd_keep == h_keep && cmd_kind == h_kind)) hold_bad = 1;
      if (cmd_valid && !first_seen) begin
        first_seen = 1;
        if (mode != (8'h80 | 8'(exp_shift))) mode_bad = 1;
      end
      if (cmd_valid && cmd_ready) begin
        if (got >= n_exp) begin
          if (bad == 0) begin bad_act = got; bad_exp = n_exp; end
          bad++;
        end else if (int'(cmd_kind) != e_kind[got] || int'(cmd_src) != e_src[got] ||
                     int'(cmd_dst) != e_dst[got] || int'(cmd_keep) != e_keep[got] ||
                     int'(cmd_shift) != exp_shift ||
                     cmd_page != (8'h0C | 8'(e_dst[got] >> 16))) begin
          if (bad == 0) begin
            bad_act = {cmd_kind, cmd_src, cmd_dst, cmd_keep};
            bad_exp = {2'(e_kind[got]), 17'(e_src[got]), 17'(e_dst[got]), 16'(e_keep[got])};
          end
          bad++;
        end
        got++;
      end
      hold = cmd_valid && !cmd_ready;
      h_src = cmd_src; h_dst = cmd_dst; h_keep = cmd_keep; h_kind = cmd_kind;
      if (done) begin
        seen_done = 1;
        check(mode == 8'hE0, "R7", {name, " mode at done"}, mode, 8'hE0);
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    start = 1'b0;
    cmd_ready = 1'b1;
    check(seen_done, "R12", {name, " done seen"}, seen_done, 1);
    check(bad == 0, "R1 R2 R4 R5 R6 R8 R9", {name, " command stream"}, bad_act, bad_exp);
    check(got == n_exp, "R3", {name, " command count"}, got, n_exp);
    check(!mode_bad, "R7", {name, " mode while copying"}, mode, 8'h80 | 8'(exp_shift));
    if (stalls) check(!hold_bad, "R11", {name, " stall hold"}, hold_bad, 0);
    if (inject) check(!hold_bad && bad == 0, "R12", {name, " start ignored while busy"}, bad, 0);
    @(negedge clk);
    check(!done && !busy, "R12", {name, " done single cycle"}, done, 0);
  endtask

  task automatic run_empty(input string name, input int w, input int h);
    bit any_cmd;
    @(negedge clk);
    src_x = 11'd40; src_y = 10'd5; dst_x = 11'd70; dst_y = 10'd9;
    width = 11'(w); height = 10'(h);
    start = 1'b1;
    any_cmd = 0;
    @(negedge clk);
    start = 1'b0;
    any_cmd |= cmd_valid;
    check(!done, "R10", {name, " no done one cycle after start"}, done, 0);
    @(negedge clk);
    any_cmd |= cmd_valid;
    check(done, "R10", {name, " done two cycles after start"}, done, 1);
    check(!any_cmd, "R10", {name, " no commands"}, any_cmd, 0);
    @(negedge clk);
    check(!done, "R12", {name, " done drops"}, done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cmd_valid && !done && !busy, "R12", "reset idle outputs", {cmd_valid, done, busy}, 0);
    check(mode == 8'hE0, "R7", "reset mode", mode, 8'hE0);
    // forward, dummy read, several words
    run_copy("fwd_pre", 5, 10, 20, 3, 40, 3, 1'b0, 1'b0);
    // forward, no dummy read, high rows set the page bit
    run_copy("fwd_page", 3, 600, 9, 600, 70, 2, 1'b0, 1'b0);
    // backward with stalls and a dummy read
    run_copy("bwd_pre_stall", 100, 2, 37, 50, 50, 3, 1'b1, 1'b0);
    // backward single word, no dummy read
    run_copy("bwd_single", 40, 8, 18, 20, 5, 2, 1'b0, 1'b0);
    // forward single word with stalls
    run_copy("fwd_single", 7, 30, 2, 30, 3, 4, 1'b1, 1'b0);
    // start pulse while busy
    run_copy("busy_start", 17, 40, 48, 12, 60, 3, 1'b1, 1'b1);
    run_empty("zero_height", 30, 0);
    run_empty("zero_width", 0, 4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule